// File: doc/BRIEF.md
# Guarded Nonvolatile Register Write Controller

This block takes byte-level events from a serial bus front end and decides what happens to a small bank of clock/control registers. The events are a start strobe, a stop strobe, a received byte with its valid flag, and the count of bits left over in an unfinished byte when a stop arrives. From these the block decodes the device select byte, a one-byte register address and up to eight data bytes. It then either updates a pair of volatile enable latches or starts a protected register update.

A protected update needs two enable latches to be set first. The write-enable latch is set by writing 02h to the status address. The register-write-enable latch is then set, together with the write-enable latch, by writing 06h. When a correctly framed write finishes while both latches are set, the block copies the transaction into a staging buffer. It raises a busy flag for a parameterised number of cycles, which stands in for the nonvolatile programming time. When that time ends it writes the staged bytes into the bank and drops the register-write-enable latch. Every change to the bank therefore needs the unlock sequence again. A transaction that is framed wrongly starts nothing and leaves the latches as they were. Read transactions pass through without effect.

Top module: `nv_guarded_writer`

## Requirements
- R1: After reset, wel, rwel and busy are 0 and every bank register reads 00h.
- R2: A write of the single data byte 02h to the status address (STATUS_ADDR, default 3Fh) sets wel and leaves rwel unchanged, and busy stays 0.
- R3: A status write of 06h sets both wel and rwel, and 00h clears both. Any other value is ignored, including 06h with an extra bit set (07h, 0Eh). rwel is never 1 while wel is 0.
- R4: A write to a non-status address starts a commit only if wel and rwel are both 1 when its stop is decoded. Otherwise busy stays 0 and the bank does not change.
- R5: Only the select byte 11011110b (DEh) opens a write. A transaction with any other select byte, such as the read select DFh, changes neither the latches nor the bank, and the unlock sequence stays intact across it.
- R6: Data byte i (counting from 0) of a transaction goes to address base+i. Between one and eight bytes are accepted, and bytes after the eighth are dropped.
- R7: busy stays high for exactly COMMIT_CYCLES cycles. Bank contents read through rd_addr/rd_data keep their old values until busy falls.
- R8: When a commit completes, rwel is cleared and wel keeps its value.
- R9: A write whose stop arrives with a nonzero part_bits, or that is cut off by a repeated start, starts no commit and leaves rwel set.
- R10: Data bytes whose address is NREG (default 20) or higher are discarded. Out-of-range addresses read back as 00h.
- R11: While busy is high, every new write transaction, status writes included, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start (or repeated start) strobe, one cycle |
| bus_stop | input | 1 | Stop strobe, one cycle |
| byte_valid | input | 1 | A complete byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| part_bits | input | 3 | Bits of an unfinished byte at the time of stop; 0 means clean framing |
| rd_addr | input | 8 | Bank read address |
| rd_data | output | 8 | Committed bank contents at rd_addr, 00h when out of range |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| busy | output | 1 | Nonvolatile commit in progress |

## Verification
The bench counts the busy window edge to edge and reads the target register in the middle of a commit. A design that commits early, or that makes staged data visible before busy falls, is caught there. It unlocks, then breaks the framing with a leftover bit count or a repeated start, and checks that rwel survives and busy stays low. A design that commits on a broken frame, or that clears the enable on abort, fails this test. Overlong and out-of-range bursts expose address counters that wrap or spill past eight bytes. Status writes sent during a commit, and the 07h status value, catch latches that take updates they should refuse.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    localparam int ADDR_W    = 8;
    localparam int MAX_BYTES = 8;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_SEL,
        PS_ADDR,
        PS_DATA,
        PS_SKIP
    } parse_state_e;

    typedef enum logic [1:0] {
        ST_NONE,
        ST_CLEAR,
        ST_WEL,
        ST_BOTH
    } status_op_e;

    typedef struct packed {
        logic [ADDR_W-1:0]               base;
        logic [CNT_W-1:0]                nbytes;
        logic [MAX_BYTES-1:0][7:0]       data;
    } txn_t;

    function automatic status_op_e decode_status(input logic [7:0] v);
        case (v)
            8'h00:   return ST_CLEAR;
            8'h02:   return ST_WEL;
            8'h06:   return ST_BOTH;
            default: return ST_NONE;
        endcase
    endfunction

endpackage

// File: rtl/nvw_frame_parser.sv
module nvw_frame_parser
    import nvw_pkg::*;
#(
    parameter logic [7:0] SEL_WRITE = 8'hDE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_start,
    input  logic        bus_stop,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic [2:0]  part_bits,
    output logic        txn_done,
    output txn_t        txn
);

    parse_state_e               state_q;
    logic [ADDR_W-1:0]          base_q;
    logic [CNT_W-1:0]           cnt_q;
    logic [MAX_BYTES-1:0][7:0]  buf_q;
    logic                       frame_ok;

    // a write is complete only in the data phase, with whole bytes and at least one byte
    assign frame_ok = (state_q == PS_DATA) && (part_bits == 3'd0) && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PS_IDLE;
            base_q   <= '0;
            cnt_q    <= '0;
            buf_q    <= '0;
            txn_done <= 1'b0;
            txn      <= '0;
        end else begin
            txn_done <= 1'b0;
            if (bus_start) begin
                // a repeated start simply abandons whatever was in flight
                state_q <= PS_SEL;
                cnt_q   <= '0;
            end else if (bus_stop) begin
                if (frame_ok) begin
                    txn_done    <= 1'b1;
                    txn.base    <= base_q;
                    txn.nbytes  <= cnt_q;
                    txn.data    <= buf_q;
                end
                state_q <= PS_IDLE;
            end else if (byte_valid) begin
                case (state_q)
                    PS_SEL:  state_q <= (byte_data == SEL_WRITE) ? PS_ADDR : PS_SKIP;
                    PS_ADDR: begin
                        base_q  <= byte_data;
                        state_q <= PS_DATA;
                    end
                    PS_DATA: begin
                        if (cnt_q < CNT_W'(MAX_BYTES)) begin
                            buf_q[cnt_q[CNT_W-2:0]] <= byte_data;
                            cnt_q                   <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9
    clean_stop_chk: assert property (@(posedge clk) disable iff (rst)
        txn_done |-> ($past(bus_stop) && $past(part_bits) == 3'd0 && !$past(bus_start)));

    // R6
    byte_limit_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_BYTES));

endmodule

// File: rtl/nvw_enable_latches.sv
module nvw_enable_latches
    import nvw_pkg::*;
#(
    parameter logic [7:0] STATUS_ADDR = 8'h3F
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  txn_done,
    input  txn_t  txn,
    input  logic  busy,
    input  logic  commit_fire,
    output logic  wel,
    output logic  rwel
);

    logic       status_hit;
    status_op_e op;

    assign status_hit = txn_done && !busy && (txn.base == STATUS_ADDR)
                        && (txn.nbytes == CNT_W'(1));
    assign op         = decode_status(txn.data[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
        end else begin
            if (commit_fire) rwel <= 1'b0;
            if (status_hit) begin
                case (op)
                    ST_CLEAR: begin wel <= 1'b0; rwel <= 1'b0; end
                    ST_WEL:   wel <= 1'b1;
                    ST_BOTH:  begin wel <= 1'b1; rwel <= 1'b1; end
                    default:  ;
                endcase
            end
        end
    end

    // R3
    rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        rwel |-> wel);

    // R8
    commit_drops_rwel_chk: assert property (@(posedge clk) disable iff (rst)
        commit_fire |=> (!rwel && (wel == $past(wel))));

    // R11
    no_latch_change_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit_fire) |=> ($stable(wel) && $stable(rwel)));

    // R2
    wel_rise_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !$past(busy));

endmodule

// File: rtl/nvw_commit_engine.sv
module nvw_commit_engine
    import nvw_pkg::*;
#(
    parameter int         NREG          = 20,
    parameter int         COMMIT_CYCLES = 40,
    parameter logic [7:0] STATUS_ADDR   = 8'h3F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txn_done,
    input  txn_t               txn,
    input  logic               wel,
    input  logic               rwel,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data,
    output logic               busy,
    output logic               commit_fire
);

    localparam int TIMER_W = $clog2(COMMIT_CYCLES + 1);
    localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int AW1     = ADDR_W + 1;

    logic [TIMER_W-1:0]      timer_q;
    txn_t                    stage_q;
    logic [NREG-1:0][7:0]    bank_q;
    logic                    start_ok;

    assign start_ok    = txn_done && !busy && wel && rwel && (txn.base != STATUS_ADDR);
    assign commit_fire = busy && (timer_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            timer_q <= '0;
            stage_q <= '0;
            bank_q  <= '0;
        end else if (commit_fire) begin
            for (int i = 0; i < MAX_BYTES; i++) begin
                logic [AW1-1:0] waddr;
                waddr = {1'b0, stage_q.base} + AW1'(i);
                if ((CNT_W'(i) < stage_q.nbytes) && (waddr < AW1'(NREG)))
                    bank_q[waddr[IDX_W-1:0]] <= stage_q.data[i];
            end
            busy <= 1'b0;
        end else if (busy) begin
            timer_q <= timer_q - 1'b1;
        end else if (start_ok) begin
            stage_q <= txn;
            busy    <= 1'b1;
            timer_q <= TIMER_W'(COMMIT_CYCLES - 1);
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if ({1'b0, rd_addr} < AW1'(NREG))
            rd_data = bank_q[rd_addr[IDX_W-1:0]];
    end

    // R4
    start_needs_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel && rwel));

    // R11
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(stage_q));

    // R7
    bank_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit_fire) |=> $stable(bank_q));

    // R7
    busy_until_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit_fire) |=> busy);

    // R10
    out_of_range_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, rd_addr} >= AW1'(NREG)) |-> (rd_data == 8'h00));

endmodule

// File: rtl/nv_guarded_writer.sv
module nv_guarded_writer
    import nvw_pkg::*;
#(
    parameter int         NREG          = 20,
    parameter int         COMMIT_CYCLES = 40,
    parameter logic [7:0] STATUS_ADDR   = 8'h3F,
    parameter logic [7:0] SEL_WRITE     = 8'hDE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_start,
    input  logic        bus_stop,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic [2:0]  part_bits,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        wel,
    output logic        rwel,
    output logic        busy
);

    logic txn_done;
    txn_t txn;
    logic commit_fire;

    nvw_frame_parser #(
        .SEL_WRITE (SEL_WRITE)
    ) u_parser (
        .clk        (clk),
        .rst        (rst),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .part_bits  (part_bits),
        .txn_done   (txn_done),
        .txn        (txn)
    );

    nvw_enable_latches #(
        .STATUS_ADDR (STATUS_ADDR)
    ) u_latches (
        .clk         (clk),
        .rst         (rst),
        .txn_done    (txn_done),
        .txn         (txn),
        .busy        (busy),
        .commit_fire (commit_fire),
        .wel         (wel),
        .rwel        (rwel)
    );

    nvw_commit_engine #(
        .NREG          (NREG),
        .COMMIT_CYCLES (COMMIT_CYCLES),
        .STATUS_ADDR   (STATUS_ADDR)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .txn_done    (txn_done),
        .txn         (txn),
        .wel         (wel),
        .rwel        (rwel),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .busy        (busy),
        .commit_fire (commit_fire)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!wel && !rwel && !busy));

endmodule

// File: tb/nv_guarded_writer_bench.sv
module nv_guarded_writer_bench;

    localparam int         NREG   = 20;
    localparam int         CYC    = 40;
    localparam logic [7:0] ST_A   = 8'h3F;
    localparam logic [7:0] SEL_W  = 8'hDE;
    localparam logic [7:0] SEL_R  = 8'hDF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_start = 1'b0, bus_stop = 1'b0, byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [2:0] part_bits = 3'd0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       wel, rwel, busy;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [NREG];

    always #4 clk = ~clk;

    nv_guarded_writer #(.NREG(NREG), .COMMIT_CYCLES(CYC)) u_nv_guarded_writer (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .byte_valid(byte_valid), .byte_data(byte_data), .part_bits(part_bits),
        .rd_addr(rd_addr), .rd_data(rd_data), .wel(wel), .rwel(rwel), .busy(busy)
    );

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic ev_stop(input logic [2:0] pb);
        @(negedge clk); bus_stop = 1'b1; part_bits = pb;
        @(negedge clk); bus_stop = 1'b0; part_bits = 3'd0;
    endtask

    task automatic ev_byte(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic send_write(input logic [7:0] sel, input logic [7:0] base,
                              input int n, input logic [7:0] seed, input logic [2:0] pb);
        ev_start();
        ev_byte(sel);
        ev_byte(base);
        for (int i = 0; i < n; i++) ev_byte(pat(seed, i));
        ev_stop(pb);
    endtask

    task automatic status_wr(input logic [7:0] v);
        ev_start(); ev_byte(SEL_W); ev_byte(ST_A); ev_byte(v); ev_stop(3'd0);
        settle();
    endtask

    task automatic model_apply(input logic [7:0] base, input int n, input logic [7:0] seed);
        for (int i = 0; i < n && i < 8; i++)
            if (int'(base) + i < NREG) model[int'(base) + i] = pat(seed, i);
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic check_bank(input string req);
        int mism = 0;
        logic [7:0] v;
        for (int a = 0; a < NREG; a++) begin
            read_reg(8'(a), v);
            if (v !== model[a]) begin
                mism++;
                $display("FAIL %s reg %0d: actual=%0h expected=%0h", req, a, v, model[a]);
            end
        end
        total++;
        if (mism != 0) bad++;
    endtask

    // waits for a commit started by the last stop and measures the busy window
    task automatic wait_commit(output int width);
        int guard = 0;
        width = 0;
        while (!busy && guard < 8) begin @(negedge clk); guard++; end
        while (busy && width < 4 * CYC) begin width++; @(negedge clk); end
    endtask

    task automatic unlock();
        status_wr(8'h02);
        status_wr(8'h06);
    endtask

    task automatic t_reset();
        check("R1", "wel", wel, 0);
        check("R1", "rwel", rwel, 0);
        check("R1", "busy", busy, 0);
        check_bank("R1");
    endtask

    task automatic t_wel_only();
        status_wr(8'h02);
        check("R2", "wel after 02h", wel, 1);
        check("R2", "rwel after 02h", rwel, 0);
        check("R2", "busy after 02h", busy, 0);
    endtask

    task automatic t_status_codes();
        status_wr(8'h06);
        check("R3", "wel after 06h", wel, 1);
        check("R3", "rwel after 06h", rwel, 1);
        status_wr(8'h00);
        check("R3", "wel after 00h", wel, 0);
        check("R3", "rwel after 00h", rwel, 0);
        status_wr(8'h02);
        status_wr(8'h07);
        check("R3", "rwel after 07h", rwel, 0);
        status_wr(8'h0E);
        check("R3", "rwel after 0Eh", rwel, 0);
        check("R3", "wel kept after bad codes", wel, 1);
    endtask

    task automatic t_locked_write();
        // wel alone is set here
        send_write(SEL_W, 8'h01, 2, 8'h55, 3'd0);
        settle();
        check("R4", "busy with rwel clear", busy, 0);
        check_bank("R4");
    endtask

    task automatic t_read_between();
        int w;
        status_wr(8'h00);
        status_wr(8'h02);
        send_write(SEL_R, 8'h3F, 1, 8'h00, 3'd0);
        settle();
        check("R5", "wel after read", wel, 1);
        status_wr(8'h06);
        send_write(SEL_R, 8'h02, 3, 8'h11, 3'd0);
        settle();
        check("R5", "rwel after read", rwel, 1);
        check("R5", "no busy from read", busy, 0);
        check_bank("R5");
        send_write(8'hA0, 8'h03, 1, 8'h22, 3'd0);
        settle();
        check("R5", "no busy from foreign select", busy, 0);
        send_write(SEL_W, 8'h02, 1, 8'hC3, 3'd0);
        model_apply(8'h02, 1, 8'hC3);
        wait_commit(w);
        check("R5", "commit after reads", w, CYC);
        check_bank("R5");
    endtask

    task automatic t_multi_byte();
        int w = 0;
        logic [7:0] v;
        logic [7:0] old4;
        unlock();
        old4 = model[4];
        send_write(SEL_W, 8'h04, 3, 8'h3A, 3'd0);
        @(negedge clk); @(negedge clk);
        check("R7", "busy raised", busy, 1);
        repeat (CYC / 2) @(negedge clk);
        read_reg(8'h04, v);
        check("R7", "old value visible mid-commit", v, old4);
        model_apply(8'h04, 3, 8'h3A);
        while (busy && w < 4 * CYC) begin w++; @(negedge clk); end
        check_bank("R6");
        check("R8", "rwel after commit", rwel, 0);
        check("R8", "wel after commit", wel, 1);
        send_write(SEL_W, 8'h00, 1, 8'h99, 3'd0);
        settle();
        check("R8", "second write needs unlock", busy, 0);
    endtask

    task automatic t_busy_width();
        int w;
        unlock();
        send_write(SEL_W, 8'h0A, 1, 8'h5C, 3'd0);
        model_apply(8'h0A, 1, 8'h5C);
        wait_commit(w);
        check("R7", "busy width", w, CYC);
        check_bank("R7");
    endtask

    task automatic t_overlong();
        int w;
        unlock();
        send_write(SEL_W, 8'h08, 10, 8'h71, 3'd0);
        model_apply(8'h08, 10, 8'h71);
        wait_commit(w);
        check_bank("R6");
    endtask

    task automatic t_out_of_range();
        int w;
        logic [7:0] v;
        unlock();
        send_write(SEL_W, 8'(NREG - 2), 4, 8'hE4, 3'd0);
        model_apply(8'(NREG - 2), 4, 8'hE4);
        wait_commit(w);
        check_bank("R10");
        read_reg(8'(NREG), v);
        check("R10", "beyond range reads zero", v, 0);
        read_reg(8'h30, v);
        check("R10", "far address reads zero", v, 0);
    endtask

    task automatic t_bad_framing();
        int w;
        unlock();
        send_write(SEL_W, 8'h01, 2, 8'h0F, 3'd3);
        settle();
        check("R9", "busy after partial byte", busy, 0);
        check("R9", "rwel kept after partial byte", rwel, 1);
        ev_start(); ev_byte(SEL_W); ev_byte(8'h01); ev_byte(8'h6B);
        ev_start(); ev_stop(3'd0);
        settle();
        check("R9", "busy after repeated start", busy, 0);
        check("R9", "rwel kept after repeated start", rwel, 1);
        check_bank("R9");
        send_write(SEL_W, 8'h01, 1, 8'h6B, 3'd0);
        model_apply(8'h01, 1, 8'h6B);
        wait_commit(w);
        check("R9", "clean write commits", w, CYC);
        check_bank("R9");
    endtask

    task automatic t_busy_ignore();
        int g = 0;
        unlock();
        send_write(SEL_W, 8'h0C, 1, 8'h2D, 3'd0);
        model_apply(8'h0C, 1, 8'h2D);
        repeat (2) @(negedge clk);
        send_write(SEL_W, ST_A, 1, 8'h00 - 8'h00, 3'd0);  // status 00h during busy
        send_write(SEL_W, 8'h05, 2, 8'h81, 3'd0);
        while (busy && g < 4 * CYC) begin g++; @(negedge clk); end
        check("R11", "wel after ignored clear", wel, 1);
        check("R11", "rwel cleared by commit only", rwel, 0);
        settle();
        check("R11", "no queued commit", busy, 0);
        check_bank("R11");
    endtask

    initial begin
        for (int a = 0; a < NREG; a++) model[a] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wel_only();
        t_status_codes();
        t_locked_write();
        t_read_between();
        t_multi_byte();
        t_busy_width();
        t_overlong();
        t_out_of_range();
        t_bad_framing();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule